// File: doc/BRIEF.md
# Overlay Color Palette Pixel Pipeline

This block sits between a pixel generator and a triple video DAC. It takes an 8-bit pixel index and a 2-bit overlay select each pixel clock and returns a 24-bit RGB code, 8 bits per channel. When the overlay select is zero, the code comes from a 256-entry color table. Otherwise it comes from one of three overlay color registers, which can draw cursors, menus or grids over the picture. The blank and sync controls and a host chip-select travel through the same pipeline, so the flags that come out stay aligned with the color they belong to.

The pixel stream carries a valid flag but has no ready signal. The downstream DAC consumes one word on every pixel clock, so back-pressure is not supported and the sink must accept every cycle. Pixel-rate data does not stall. The valid flag only marks which output words came from valid input pixels. A separate write port loads the table and the overlay registers. Table lookups use their own read port, so writes never interrupt the pixel stream.

Top module: `palette_pipe`

## Requirements
- R1: While reset is asserted (rst_n low), out_rgb is 0, out_blank is 1, out_sync is 0 and out_valid is 0. Reset clears all three overlay registers to 0. The color table is not cleared.
- R2: With blank_n high, host_cs_n high and ovl_sel equal to 0, out_rgb is the table entry addressed by pix_index. Red is bits 23:16, green is bits 15:8 and blue is bits 7:0.
- R3: With blank_n high, host_cs_n high and ovl_sel equal to 1, 2 or 3, out_rgb is the overlay register with that number, and pix_index has no effect.
- R4: Every output reflects the inputs captured on the rising edge two pixel clocks earlier. RGB, blank, sync and valid come from the same capture edge.
- R5: When blank_n is captured low, out_rgb is 0 and out_blank is 1, and pix_index, ovl_sel and host_cs_n have no effect.
- R6: When host_cs_n is captured low and blank_n is captured high, out_rgb is 0 (black) and out_blank is 0.
- R7: out_sync equals the captured sync_n (1 means sync contribution on), whatever the blank, select and chip-select inputs are.
- R8: When wr_en is high and wr_ovl is 0, wr_data is written into table entry wr_addr. When wr_en is high and wr_ovl is 1, wr_data is written into overlay register wr_addr[1:0] if that value is 1 to 3. A value of 0 is ignored.
- R9: A lookup captured on the same edge as a write to the same location returns the old content. Lookups captured on later edges return the new content.
- R10: out_valid equals pix_valid delayed by two pixel clocks. The sink must accept a word on every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock; all inputs are captured on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| pix_valid | input | 1 | Marks the pixel on pix_index/ovl_sel as valid |
| pix_index | input | 8 | Color table address |
| ovl_sel | input | 2 | 0 selects the table; 1 to 3 select an overlay register |
| blank_n | input | 1 | Active-low blank |
| sync_n | input | 1 | Active-low sync |
| host_cs_n | input | 1 | Active-low host select; forces black while low |
| wr_en | input | 1 | Write strobe for table or overlay |
| wr_ovl | input | 1 | 0 writes the table, 1 writes an overlay register |
| wr_addr | input | 8 | Table entry, or overlay number in bits 1:0 |
| wr_data | input | 24 | Color to store, red in bits 23:16 |
| out_valid | output | 1 | Delayed pix_valid |
| out_rgb | output | 24 | Color code for the DAC |
| out_blank | output | 1 | High when the word is at the blanking level |
| out_sync | output | 1 | High when the sync contribution is on |

## Verification
Every output is due exactly two rising edges after the inputs it depends on are captured. Writes count from the edge they are captured on, and a lookup on that same edge still sees the old color. The bench has a reference model that keeps expected words in a two-entry stage. The model updates at each rising edge, and the bench compares all four outputs at the following falling edge. Writes are applied to the model only after that edge's lookup has been computed. This keeps the read-before-write case and the two-cycle delay in step without any per-test timing.

// File: rtl/palette_pkg.sv
package palette_pkg;
  // Pipeline control flags travelling alongside the color data
  typedef struct packed {
    logic valid;
    logic blank;   // 1 = blanking level
    logic sync;    // 1 = sync contribution on
    logic black;   // 1 = host forces black
  } pix_ctl_t;

  localparam pix_ctl_t CTL_RESET = '{valid: 1'b0, blank: 1'b1, sync: 1'b0, black: 1'b0};
endpackage

// File: rtl/palette_table.sv
module palette_table #(
  parameter int AW = 8,
  parameter int DW = 24
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  // Read-before-write: a same-edge read returns the old entry
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/overlay_bank.sv
module overlay_bank #(
  parameter int SW = 2,
  parameter int DW = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [SW-1:0] wsel,
  input  logic [DW-1:0] wdata,
  input  logic [SW-1:0] rsel,
  output logic [DW-1:0] rdata
);
  localparam int NREG = (1 << SW) - 1;

  logic [DW-1:0] ovl_q [NREG];
  logic [DW-1:0] rd_mux;

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                   ovl_q[g] <= '0;
      else if (we && (wsel == SW'(g + 1)))          ovl_q[g] <= wdata;
    end
  end

  always_comb begin
    rd_mux = '0;
    for (int i = 0; i < NREG; i++)
      if (rsel == SW'(i + 1)) rd_mux = ovl_q[i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata <= '0;
    else        rdata <= rd_mux;
  end
endmodule

// File: rtl/color_select.sv
module color_select
  import palette_pkg::*;
#(
  parameter int DW = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  pix_ctl_t      ctl_in,
  input  logic          ovl_hit,
  input  logic [DW-1:0] tab_color,
  input  logic [DW-1:0] ovl_color,
  output logic          out_valid,
  output logic [DW-1:0] out_rgb,
  output logic          out_blank,
  output logic          out_sync
);
  logic [DW-1:0] color_d;

  // Priority: blank, then host black-force, then overlay, then table
  always_comb begin
    if (ctl_in.blank || ctl_in.black) color_d = '0;
    else if (ovl_hit)                 color_d = ovl_color;
    else                              color_d = tab_color;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_rgb   <= '0;
      out_blank <= 1'b1;
      out_sync  <= 1'b0;
    end else begin
      out_valid <= ctl_in.valid;
      out_rgb   <= color_d;
      out_blank <= ctl_in.blank;
      out_sync  <= ctl_in.sync;
    end
  end
endmodule

// File: rtl/palette_pipe.sv
module palette_pipe
  import palette_pkg::*;
#(
  parameter int IDX_W = 8,
  parameter int SEL_W = 2,
  parameter int CH_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pix_valid,
  input  logic [IDX_W-1:0]  pix_index,
  input  logic [SEL_W-1:0]  ovl_sel,
  input  logic              blank_n,
  input  logic              sync_n,
  input  logic              host_cs_n,
  input  logic              wr_en,
  input  logic              wr_ovl,
  input  logic [IDX_W-1:0]  wr_addr,
  input  logic [3*CH_W-1:0] wr_data,
  output logic              out_valid,
  output logic [3*CH_W-1:0] out_rgb,
  output logic              out_blank,
  output logic              out_sync
);
  localparam int RGB_W = 3 * CH_W;

  pix_ctl_t         ctl_s1;
  logic             ovl_hit_s1;
  logic [RGB_W-1:0] tab_rd;
  logic [RGB_W-1:0] ovl_rd;

  // Stage 1: capture controls; table and overlay reads register in parallel
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_s1     <= CTL_RESET;
      ovl_hit_s1 <= 1'b0;
    end else begin
      ctl_s1.valid <= pix_valid;
      ctl_s1.blank <= ~blank_n;
      ctl_s1.sync  <= sync_n;
      ctl_s1.black <= ~host_cs_n;
      ovl_hit_s1   <= |ovl_sel;
    end
  end

  palette_table #(.AW(IDX_W), .DW(RGB_W)) i_table (
    .clk   (clk),
    .we    (wr_en & ~wr_ovl),
    .waddr (wr_addr),
    .wdata (wr_data),
    .raddr (pix_index),
    .rdata (tab_rd)
  );

  overlay_bank #(.SW(SEL_W), .DW(RGB_W)) i_ovl (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (wr_en & wr_ovl),
    .wsel  (wr_addr[SEL_W-1:0]),
    .wdata (wr_data),
    .rsel  (ovl_sel),
    .rdata (ovl_rd)
  );

  // Stage 2: final selection into the output registers
  color_select #(.DW(RGB_W)) i_sel (
    .clk       (clk),
    .rst_n     (rst_n),
    .ctl_in    (ctl_s1),
    .ovl_hit   (ovl_hit_s1),
    .tab_color (tab_rd),
    .ovl_color (ovl_rd),
    .out_valid (out_valid),
    .out_rgb   (out_rgb),
    .out_blank (out_blank),
    .out_sync  (out_sync)
  );
endmodule

// File: rtl/palette_pipe_chk.sv
module palette_pipe_chk #(
  parameter int RGB_W = 24
) (
  input logic             clk,
  input logic             rst_n,
  input logic             pix_valid,
  input logic             blank_n,
  input logic             sync_n,
  input logic             host_cs_n,
  input logic             out_valid,
  input logic [RGB_W-1:0] out_rgb,
  input logic             out_blank,
  input logic             out_sync
);
  logic [1:0] cyc;
  logic       rst_seen = 1'b0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         cyc <= '0;
    else if (cyc != 2'd3) cyc <= cyc + 2'd1;
  end

  always_ff @(posedge clk) if (!rst_n) rst_seen <= 1'b1;

  a_r1_reset_blank: assert property (@(posedge clk)
    (!rst_n && rst_seen) |-> (out_blank && out_rgb == '0 && !out_valid && !out_sync));

  a_r5_blank_black: assert property (@(posedge clk) disable iff (!rst_n)
    out_blank |-> out_rgb == '0);

  a_r10_valid_delay: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc >= 2'd2) |-> out_valid == $past(pix_valid, 2));

  a_r7_sync_delay: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc >= 2'd2) |-> out_sync == $past(sync_n, 2));

  a_r4_blank_delay: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc >= 2'd2) |-> out_blank == !$past(blank_n, 2));

  a_r6_cs_black: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc >= 2'd2 && !$past(host_cs_n, 2) && $past(blank_n, 2)) |-> (out_rgb == '0 && !out_blank));
endmodule

bind palette_pipe palette_pipe_chk #(.RGB_W(3 * CH_W)) i_palette_pipe_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .pix_valid (pix_valid),
  .blank_n   (blank_n),
  .sync_n    (sync_n),
  .host_cs_n (host_cs_n),
  .out_valid (out_valid),
  .out_rgb   (out_rgb),
  .out_blank (out_blank),
  .out_sync  (out_sync)
);

// File: tb/test_palette_pipe.sv
module test_palette_pipe;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pix_valid = 1'b0;
  logic [7:0]  pix_index = '0;
  logic [1:0]  ovl_sel = '0;
  logic        blank_n = 1'b0;
  logic        sync_n = 1'b1;
  logic        host_cs_n = 1'b1;
  logic        wr_en = 1'b0;
  logic        wr_ovl = 1'b0;
  logic [7:0]  wr_addr = '0;
  logic [23:0] wr_data = '0;
  logic        out_valid;
  logic [23:0] out_rgb;
  logic        out_blank;
  logic        out_sync;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  palette_pipe i_palette_pipe (
    .clk(clk), .rst_n(rst_n), .pix_valid(pix_valid), .pix_index(pix_index),
    .ovl_sel(ovl_sel), .blank_n(blank_n), .sync_n(sync_n), .host_cs_n(host_cs_n),
    .wr_en(wr_en), .wr_ovl(wr_ovl), .wr_addr(wr_addr), .wr_data(wr_data),
    .out_valid(out_valid), .out_rgb(out_rgb), .out_blank(out_blank), .out_sync(out_sync)
  );

  // Reference model: behavioural arrays and a two-deep expected stage
  logic [23:0] m_tab [256];
  logic [23:0] m_ovl [4];
  typedef struct {
    logic [23:0] rgb;
    logic        blank;
    logic        sync;
    logic        valid;
    string       tag;
  } exp_t;
  exp_t st1, expq;

  function automatic exp_t reset_word();
    exp_t e;
    e.rgb = '0; e.blank = 1'b1; e.sync = 1'b0; e.valid = 1'b0; e.tag = "R1";
    return e;
  endfunction

  initial begin
    st1 = reset_word();
    expq = reset_word();
    for (int i = 0; i < 4; i++) m_ovl[i] = '0;
  end

  always @(posedge clk) begin
    if (!rst_n) begin
      st1 = reset_word();
      expq = reset_word();
      for (int i = 0; i < 4; i++) m_ovl[i] = '0;
    end else begin
      exp_t e;
      expq = st1;
      e.sync = sync_n;
      e.valid = pix_valid;
      if (!blank_n) begin e.rgb = '0; e.blank = 1'b1; e.tag = "R5"; end
      else if (!host_cs_n) begin e.rgb = '0; e.blank = 1'b0; e.tag = "R6"; end
      else if (ovl_sel != 0) begin e.rgb = m_ovl[ovl_sel]; e.blank = 1'b0; e.tag = "R3"; end
      else begin e.rgb = m_tab[pix_index]; e.blank = 1'b0; e.tag = "R2"; end
      st1 = e;
      // writes land after the same-edge lookup (R9)
      if (wr_en && !wr_ovl) m_tab[wr_addr] = wr_data;
      if (wr_en && wr_ovl && wr_addr[1:0] != 0) m_ovl[wr_addr[1:0]] = wr_data;
    end
  end

  task automatic check(input string req, input logic [23:0] act, input logic [23:0] exp_v);
    checks++;
    if (act !== exp_v) begin
      errors++;
      $display("FAIL %s at %0t: actual=%h expected=%h", req, $time, act, exp_v);
    end
  endtask

  always @(negedge clk) begin
    if (!done) begin
      check({expq.tag, " rgb"}, out_rgb, expq.rgb);
      check("R4 blank", {23'd0, out_blank}, {23'd0, expq.blank});
      check("R7 sync", {23'd0, out_sync}, {23'd0, expq.sync});
      check("R10 valid", {23'd0, out_valid}, {23'd0, expq.valid});
    end
  end

  task automatic step(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic put_pix(input logic [7:0] idx, input logic [1:0] sel);
    pix_index = idx; ovl_sel = sel; pix_valid = 1'b1;
    step(1);
  endtask

  task automatic write(input logic ovl, input logic [7:0] a, input logic [23:0] d);
    wr_en = 1'b1; wr_ovl = ovl; wr_addr = a; wr_data = d;
    step(1);
    wr_en = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    // R1: reset state, also with active pixels and blank released
    blank_n = 1'b1; pix_valid = 1'b1; ovl_sel = 2'd1;
    step(4);
    blank_n = 1'b0; pix_valid = 1'b0; ovl_sel = 2'd0;
    rst_n = 1'b1;
    // R8: fill table while blanked (R5 masks unknown reads)
    for (int i = 0; i < 256; i++) begin
      sync_n = i[0];
      write(1'b0, 8'(i), {8'(i), ~8'(i), 8'(i) ^ 8'h5a});
    end
    // R1: overlay registers read zero before any overlay write
    blank_n = 1'b1;
    for (int s = 1; s < 4; s++) put_pix(8'h33, 2'(s));
    // R8: overlay writes, address 0 ignored
    write(1'b1, 8'd1, 24'hff0000);
    write(1'b1, 8'd2, 24'h00ff00);
    write(1'b1, 8'd3, 24'h0000ff);
    write(1'b1, 8'd0, 24'h123456);
    write(1'b1, 8'd4, 24'habcdef);
    // R2: table lookups with a gapped valid pattern
    for (int i = 0; i < 40; i++) begin
      pix_valid = (i % 3) != 0;
      pix_index = 8'($urandom);
      ovl_sel = 2'd0;
      sync_n = (i % 5) != 0;
      step(1);
    end
    // R3: overlay selects with changing index
    for (int i = 0; i < 24; i++) put_pix(8'($urandom), 2'(1 + i % 3));
    // R5: blank ignores index, select and host select
    blank_n = 1'b0;
    for (int i = 0; i < 12; i++) begin
      host_cs_n = i[0];
      sync_n = i[1];
      put_pix(8'($urandom), 2'(i % 4));
    end
    blank_n = 1'b1; sync_n = 1'b1;
    // R6: host select forces black over table and overlay
    host_cs_n = 1'b0;
    for (int i = 0; i < 8; i++) put_pix(8'(i * 17), 2'(i % 4));
    host_cs_n = 1'b1;
    // R9: same-edge write and lookup of table entry and overlay register
    pix_index = 8'h40; ovl_sel = 2'd0;
    write(1'b0, 8'h40, 24'hc0ffee);
    put_pix(8'h40, 2'd0);
    ovl_sel = 2'd2;
    write(1'b1, 8'd2, 24'h777777);
    put_pix(8'h00, 2'd2);
    // write during a lookup elsewhere, then interleave
    for (int i = 0; i < 16; i++) begin
      pix_index = 8'(i); ovl_sel = 2'(i % 2);
      write(1'b0, 8'(i + 1), 24'(i * 24'h010203));
    end
    for (int i = 0; i < 17; i++) put_pix(8'(i), 2'd0);
    // R1: mid-run reset clears overlays, table retained
    rst_n = 1'b0;
    step(3);
    rst_n = 1'b1;
    for (int s = 1; s < 4; s++) put_pix(8'h10, 2'(s));
    for (int i = 0; i < 8; i++) put_pix(8'(i * 31), 2'd0);
    pix_valid = 1'b0;
    step(4);
    finish_run();
  end
endmodule